// File: doc/BRIEF.md
# Table-Driven Sample Strobe Generator

This block creates the sampling strobe for one receive channel of an ultrasound beamformer. All timing is counted in periods of a fast base clock. A line begins with a single-cycle `line_start` pulse. The block then waits an initial delay, emits the first strobe, and after that emits one strobe every `N` base clocks, where `N` is the current sample interval.

The interval does not stay fixed for the whole line. It is held constant until a focal point named in a small correction table is reached, and then it moves by exactly one clock, up or down. Each table word carries a focal point number and a direction bit. The block reads the table through a synchronous port, one entry at a time, so the table only has to hold the points where the interval changes, not a delay for every sample. The table contents are computed offline so that the generated sample times stay within a few base clocks of the ideal ones.

One instance serves one channel. The logic is small enough to be repeated for every channel of a wide array.

Top module: `sample_strobe_gen`

## Requirements
- R1: After reset, `strobe` is 0, `fp_count` is 0 and `tbl_rd` is 0, and they stay so until the first `line_start`.
- R2: When `line_start` is sampled at clock edge E0, `fp_count` reads 0 and `strobe` is low after E0. The first strobe is high for the cycle that follows edge E0+`init_dly`+1.
- R3: While no correction applies, consecutive strobes are exactly `N` clock cycles apart, where `N` is the current interval (initially `init_intv`).
- R4: `fp_count` increments by one with each strobe, so during the k-th strobe of a line it reads k.
- R5: A table word is `{focal[FP_W-1:0], dir}`. Bit 0 set to 1 means lengthen and 0 means shorten. The port has a one-cycle read latency. `line_start` reads address 0. When the k-th strobe is emitted and the pending entry's focal number equals k, the gap after that strobe is the old interval ±1, and the next address is read. The interval never moves by more than one clock per cycle.
- R6: Corrections on consecutive strobes are all applied, for any interval including 1.
- R7: An entry whose focal number is all ones ends the corrections: the interval stays fixed for the rest of the line.
- R8: The interval saturates at 1 and at 2^INTV_W-1 instead of wrapping. An `init_intv` of 0 is treated as 1, and the interval is never 0.
- R9: A line emits exactly `samples` strobes (captured at `line_start`) and then stays silent. A `samples` value of 0 gives no strobe.
- R10: A `line_start` during a running line abandons that line at once and starts the new one from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_start | input | 1 | Single-cycle pulse that starts a receive line |
| init_intv | input | INTV_W | Sample interval at the start of the line, in clocks |
| init_dly | input | DLY_W | Clocks from the line start to the first strobe, minus one |
| samples | input | FP_W | Number of strobes in the line |
| tbl_rd | output | 1 | Table read enable |
| tbl_addr | output | ADDR_W | Table read address |
| tbl_data | input | FP_W+1 | Table word, valid the cycle after the read |
| strobe | output | 1 | Sample strobe, one cycle high per sample |
| fp_count | output | FP_W | Focal points (strobes) emitted in the current line |

## Verification
The bound checker watches four things on every cycle. The interval is never zero. The interval moves by at most one clock between cycles unless a line restarts. The strobe counter advances exactly when a strobe appears and holds otherwise. No strobe appears in the cycle right after a line start. Only the bench can show the timing itself: the absolute time of every strobe, the match between table entries and interval changes, the end marker, saturation, the per-line strobe count and line abort. It checks these against a reference model that reads the same table contents.

// File: rtl/ssg_pkg.sv
`timescale 1ns/1ps
package ssg_pkg;
  // Direction code carried in bit 0 of a correction table word.
  typedef enum logic {
    STEP_DN = 1'b0,
    STEP_UP = 1'b1
  } step_e;
endpackage

// File: rtl/ssg_intv_ctrl.sv
`timescale 1ns/1ps
module ssg_intv_ctrl
  import ssg_pkg::*;
#(
  parameter int INTV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [INTV_W-1:0] init_intv,
  input  logic              apply,
  input  step_e             dir,
  output logic [INTV_W-1:0] intv_q,
  output logic [INTV_W-1:0] intv_nxt
);
  localparam logic [INTV_W-1:0] IMAX = '1;
  localparam logic [INTV_W-1:0] IMIN = INTV_W'(1);

  logic [INTV_W-1:0] adj;
  logic [INTV_W-1:0] intv_d;
  logic              intv_en;

  // one-step change, clamped at both ends
  always_comb begin
    if (dir == STEP_UP) adj = (intv_q == IMAX) ? intv_q : intv_q + IMIN;
    else                adj = (intv_q <= IMIN) ? IMIN   : intv_q - IMIN;
  end

  assign intv_nxt = apply ? adj : intv_q;

  always_comb begin
    intv_en = line_start | apply;
    if (line_start) intv_d = (init_intv == '0) ? IMIN : init_intv;
    else            intv_d = intv_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       intv_q <= IMIN;
    else if (intv_en) intv_q <= intv_d;
  end
endmodule

// File: rtl/ssg_tbl_fetch.sv
`timescale 1ns/1ps
module ssg_tbl_fetch
  import ssg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int FP_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              advance,
  input  logic [FP_W-1:0]   fp_probe,
  input  logic [FP_W:0]     tbl_data,
  output logic              tbl_rd,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic              match,
  output step_e             match_dir
);
  localparam int ENT_W = FP_W + 1;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              pend_q;
  logic [ENT_W-1:0]  ent_q;
  logic [ENT_W-1:0]  cur;
  logic [FP_W-1:0]   cur_fp;
  logic              cur_end;

  always_comb begin
    if (line_start)   ptr_d = '0;
    else if (advance) ptr_d = ptr_q + ADDR_W'(1);
    else              ptr_d = ptr_q;
  end

  assign tbl_rd   = line_start | advance;
  assign tbl_addr = ptr_d;

  // word just read is used straight from the port, then held locally
  assign cur       = pend_q ? tbl_data : ent_q;
  assign cur_fp    = cur[ENT_W-1:1];
  assign cur_end   = &cur_fp;
  assign match     = !cur_end && (cur_fp == fp_probe);
  assign match_dir = step_e'(cur[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (tbl_rd) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= tbl_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '1;
    else if (pend_q) ent_q <= tbl_data;
  end
endmodule

// File: rtl/ssg_timer.sv
`timescale 1ns/1ps
module ssg_timer #(
  parameter int DLY_W  = 11,
  parameter int INTV_W = 8,
  parameter int FP_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [DLY_W-1:0]  init_dly,
  input  logic [FP_W-1:0]   samples,
  input  logic [INTV_W-1:0] intv_nxt,
  output logic              fire,
  output logic [FP_W-1:0]   fpc_next,
  output logic              strobe,
  output logic [FP_W-1:0]   fp_count
);
  localparam int CNT_W = (DLY_W > INTV_W) ? DLY_W : INTV_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic [FP_W-1:0]  fpc_q, fpc_d;
  logic [FP_W-1:0]  smp_q, smp_d;
  logic             stb_q, stb_d;

  assign fire     = act_q && (cnt_q == '0);
  assign fpc_next = fpc_q + FP_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    fpc_d = fpc_q;
    smp_d = smp_q;
    stb_d = 1'b0;
    if (line_start) begin
      cnt_d = CNT_W'(init_dly);
      act_d = (samples != '0);
      fpc_d = '0;
      smp_d = samples;
    end else if (fire) begin
      stb_d = 1'b1;
      fpc_d = fpc_next;
      cnt_d = CNT_W'(intv_nxt) - CNT_W'(1);
      act_d = (fpc_next != smp_q);
    end else if (act_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      fpc_q <= '0;
      smp_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      fpc_q <= fpc_d;
      smp_q <= smp_d;
      stb_q <= stb_d;
    end
  end

  assign strobe   = stb_q;
  assign fp_count = fpc_q;
endmodule

// File: rtl/sample_strobe_gen.sv
`timescale 1ns/1ps
module sample_strobe_gen
  import ssg_pkg::*;
#(
  parameter int INTV_W = 8,
  parameter int DLY_W  = 11,
  parameter int FP_W   = 12,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [INTV_W-1:0] init_intv,
  input  logic [DLY_W-1:0]  init_dly,
  input  logic [FP_W-1:0]   samples,
  output logic              tbl_rd,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [FP_W:0]     tbl_data,
  output logic              strobe,
  output logic [FP_W-1:0]   fp_count
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              fire;
  logic              match;
  logic              apply;
  step_e             match_dir;
  logic [FP_W-1:0]   fpc_next;
  logic [INTV_W-1:0] intv_q;
  logic [INTV_W-1:0] intv_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign apply = fire & match;

  ssg_timer #(.DLY_W(DLY_W), .INTV_W(INTV_W), .FP_W(FP_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .line_start (line_start),
    .init_dly   (init_dly),
    .samples    (samples),
    .intv_nxt   (intv_nxt),
    .fire       (fire),
    .fpc_next   (fpc_next),
    .strobe     (strobe),
    .fp_count   (fp_count)
  );

  ssg_intv_ctrl #(.INTV_W(INTV_W)) u_intv (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .line_start (line_start),
    .init_intv  (init_intv),
    .apply      (apply),
    .dir        (match_dir),
    .intv_q     (intv_q),
    .intv_nxt   (intv_nxt)
  );

  ssg_tbl_fetch #(.ADDR_W(ADDR_W), .FP_W(FP_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .line_start (line_start),
    .advance    (apply),
    .fp_probe   (fpc_next),
    .tbl_data   (tbl_data),
    .tbl_rd     (tbl_rd),
    .tbl_addr   (tbl_addr),
    .match      (match),
    .match_dir  (match_dir)
  );
endmodule

// File: rtl/ssg_checker.sv
`timescale 1ns/1ps
module ssg_checker #(
  parameter int INTV_W = 8,
  parameter int FP_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              strobe,
  input logic [FP_W-1:0]   fp_count,
  input logic [INTV_W-1:0] intv
);
  // R8
  intv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intv != '0);

  // R5
  intv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_start) |->
      (({1'b0, intv} == {1'b0, $past(intv)}) ||
       ({1'b0, intv} == {1'b0, $past(intv)} + 1'b1) ||
       ({1'b0, $past(intv)} == {1'b0, intv} + 1'b1)));

  // R4
  count_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (fp_count == $past(fp_count) + 1'b1));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !$past(line_start)) |-> $stable(fp_count));

  // R2
  quiet_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_start) |-> !strobe);
endmodule

bind sample_strobe_gen ssg_checker #(.INTV_W(INTV_W), .FP_W(FP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .strobe     (strobe),
  .fp_count   (fp_count),
  .intv       (intv_q)
);

// File: tb/tb_sample_strobe_gen.sv
`timescale 1ns/1ps
module tb_sample_strobe_gen;
  localparam int INTV_W = 8;
  localparam int DLY_W  = 11;
  localparam int FP_W   = 12;
  localparam int ADDR_W = 6;
  localparam int ENDFP  = (1 << FP_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              line_start;
  logic [INTV_W-1:0] init_intv;
  logic [DLY_W-1:0]  init_dly;
  logic [FP_W-1:0]   samples;
  logic              tbl_rd;
  logic [ADDR_W-1:0] tbl_addr;
  logic [FP_W:0]     tbl_data;
  logic              strobe;
  logic [FP_W-1:0]   fp_count;

  sample_strobe_gen #(.INTV_W(INTV_W), .DLY_W(DLY_W), .FP_W(FP_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .init_intv(init_intv),
    .init_dly(init_dly), .samples(samples), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .strobe(strobe), .fp_count(fp_count)
  );

  typedef struct { int t; int k; } exp_t;
  exp_t  q[$];
  int    total = 0;
  int    failed = 0;
  int    seen = 0;
  int    rel = 0;
  bit    done = 0;
  string tag = "R3";
  logic [FP_W:0] mem [0:(1<<ADDR_W)-1];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // synchronous table port, one-cycle latency
  always @(posedge clk) if (tbl_rd) tbl_data <= mem[tbl_addr];

  always @(posedge clk) begin
    if (line_start) rel <= 0;
    else            rel <= rel + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (rst_n && strobe) begin
      seen++;
      if (q.size() == 0) begin
        chk(1'b0, {tag, " R9 unexpected strobe at rel"}, rel, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rel == e.t, {tag, " R3 strobe time"}, rel, e.t);
        chk(int'(fp_count) == e.k, {tag, " R4 fp_count"}, int'(fp_count), e.k);
      end
    end
  end

  task automatic set_ent(input int a, input int fp, input bit up);
    mem[a] = {FP_W'(fp), up};
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '1;
  endtask

  // driver: starts a line and pushes the model's strobe times
  task automatic run_line(input int d, input int n, input int s, input string t, output int last);
    int iv, tm, p, fp, mx;
    mx = (1 << INTV_W) - 1;
    @(posedge clk); #2;
    init_dly = DLY_W'(d); init_intv = INTV_W'(n); samples = FP_W'(s);
    line_start = 1'b1;
    @(posedge clk); #2;
    line_start = 1'b0;
    q.delete();
    tag = t;
    chk(fp_count == '0, {t, " R2 fp_count cleared"}, int'(fp_count), 0);
    chk(strobe == 1'b0, {t, " R2 no strobe after start"}, int'(strobe), 0);
    iv = (n == 0) ? 1 : n;
    tm = d + 1;
    p = 0;
    last = 0;
    for (int k = 1; k <= s; k++) begin
      exp_t e;
      e.t = tm; e.k = k;
      q.push_back(e);
      last = tm;
      fp = int'(mem[p][FP_W:1]);
      if (fp != ENDFP && fp == k) begin
        if (mem[p][0]) iv = (iv == mx) ? mx : iv + 1;
        else           iv = (iv <= 1) ? 1 : iv - 1;
        p++;
      end
      tm += iv;
    end
  endtask

  task automatic end_line(input int last, input string t);
    while (rel <= last + 4) @(negedge clk);
    chk(q.size() == 0, {t, " R9 strobes missing"}, q.size(), 0);
  endtask

  initial begin
    int last, s0;
    line_start = 1'b0; init_intv = '0; init_dly = '0; samples = '0;
    clear_tbl();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(strobe == 1'b0, "R1 strobe", int'(strobe), 0);
    chk(fp_count == '0, "R1 fp_count", int'(fp_count), 0);
    chk(tbl_rd == 1'b0, "R1 tbl_rd", int'(tbl_rd), 0);

    // constant interval, empty table (R3)
    clear_tbl();
    run_line(7, 3, 5, "R3", last);
    end_line(last, "R3");

    // mixed corrections with end marker and a blocked entry behind it (R5, R7)
    clear_tbl();
    set_ent(0, 2, 1); set_ent(1, 3, 0); set_ent(2, 6, 1); set_ent(4, 8, 1);
    run_line(5, 4, 10, "R5,R7", last);
    end_line(last, "R5,R7");

    // back-to-back corrections at interval 1 (R6)
    clear_tbl();
    set_ent(0, 1, 1); set_ent(1, 2, 1); set_ent(2, 3, 1); set_ent(3, 4, 0);
    run_line(0, 1, 8, "R6", last);
    end_line(last, "R6");

    // low saturation and zero initial interval (R8)
    clear_tbl();
    set_ent(0, 1, 0); set_ent(1, 2, 0); set_ent(2, 4, 1);
    run_line(2, 0, 6, "R8", last);
    end_line(last, "R8");

    // high saturation (R8)
    clear_tbl();
    set_ent(0, 1, 1); set_ent(1, 2, 0);
    run_line(1, 255, 4, "R8", last);
    end_line(last, "R8");

    // zero samples: no strobe at all (R9)
    clear_tbl();
    s0 = seen;
    run_line(3, 2, 0, "R9", last);
    repeat (40) @(negedge clk);
    chk(seen == s0, "R9 zero-sample line strobes", seen - s0, 0);
    chk(fp_count == '0, "R9 fp_count idle", int'(fp_count), 0);

    // restart in the middle of a line (R10)
    clear_tbl();
    set_ent(0, 2, 1); set_ent(1, 3, 1);
    run_line(3, 5, 20, "R10", last);
    repeat (22) @(negedge clk);
    set_ent(0, 1, 0);
    run_line(2, 3, 5, "R10", last);
    end_line(last, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule